// File: doc/BRIEF.md
# Snoop Coherence Unit for a Write-Back Cache

This unit sits beside a small write-back cache and keeps its line states in step with traffic issued by other bus masters. Each line is Invalid, Shared or Modified. Every transaction another master puts on the bus is presented as a snoop: a line address, an intent flag (read or write) and a valid strobe. The unit looks the address up in its tag/state array and reports a hit one cycle later. When the line is dirty, it also raises a hit-modified flag. A snoop with write intent removes the local copy. A snoop read leaves a clean copy in place.

When a snoop finds a Modified line, the unit supplies that line directly to the requesting master as an implicit writeback. It is a visible bus transfer with a valid/ready handshake, and the memory controller can capture it to update memory. The snooping cache does not issue a separate memory write. Until the transfer completes, no further snoop is accepted. The local processor reaches the same array through a lookup port, which handles reads and write hits. A fill port installs clean lines. When a snoop and a local access target the same set in the same cycle, the snoop is served first and the local access is refused for that cycle, so it must be retried.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, `snp_ready` is 1, and `snp_hit`, `snp_hitm`, `wb_valid` and `lcl_done` are 0. A local read then reports a miss.
- R2: A snoop read that hits a Shared line gives `snp_hit`=1 and `snp_hitm`=0 one cycle after acceptance, and the line stays Shared.
- R3: A snoop with write intent that hits a Shared line gives `snp_hit`=1 and `snp_hitm`=0, and moves the line to Invalid. The next local access to that address misses, and a new fill makes it hit again.
- R4: A snoop whose set holds an Invalid line, or a line with a different tag, gives `snp_hit`=0 and `snp_hitm`=0 and changes no state.
- R5: A snoop that hits a Modified line gives both `snp_hit` and `snp_hitm` for exactly one cycle, one cycle after acceptance.
- R6: In the same cycle as `snp_hitm`, `wb_valid` rises with `wb_data` equal to the Modified line's contents and `wb_addr` equal to the snooped line address. All three hold steady until a cycle with `wb_ready`=1.
- R7: While `wb_valid` is 1, `snp_ready` is 0 and a presented snoop is neither answered nor applied. `snp_ready` returns to 1 in the cycle after the handshake.
- R8: After an implicit writeback, the line is Shared if the snoop was a read (a later snoop read gives hit without hit-modified) and Invalid if the snoop had write intent (a later snoop gives no hit).
- R9: A fill installs the line as Shared. A local write that hits makes the line Modified with the written data. A local write that misses changes nothing and reports a miss.
- R10: When a snoop is accepted in the same cycle as a local access to the same set (address bits [IDX_W-1:0]), `lcl_ready` is 0 in that cycle and the snoop acts on the old state. The local access retried in the next cycle is accepted and sees the state that the snoop left.
- R11: An accepted local access produces `lcl_done`=1 one cycle later. With it come `lcl_hit` and, for a read hit, `lcl_rdata` equal to the line data (0 otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Snoop request strobe |
| snp_addr | input | LADDR_W | Snooped line address |
| snp_wr | input | 1 | 1 = write intent, 0 = read |
| snp_ready | output | 1 | Unit can accept a snoop this cycle |
| snp_hit | output | 1 | Previous accepted snoop hit a valid line |
| snp_hitm | output | 1 | Previous accepted snoop hit a Modified line |
| wb_valid | output | 1 | Implicit writeback data present |
| wb_ready | input | 1 | Requester takes the writeback data |
| wb_addr | output | LADDR_W | Line address of the writeback |
| wb_data | output | LINE_W | Writeback line data |
| lcl_valid | input | 1 | Local access request |
| lcl_wr | input | 1 | 1 = local write, 0 = local read |
| lcl_addr | input | LADDR_W | Local line address |
| lcl_wdata | input | LINE_W | Local write data (whole line) |
| lcl_ready | output | 1 | Local access accepted this cycle |
| lcl_done | output | 1 | Result of the previous accepted local access |
| lcl_hit | output | 1 | That access hit |
| lcl_rdata | output | LINE_W | Line data on a read hit |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | LADDR_W | Address of the installed line |
| fill_data | input | LINE_W | Data of the installed line |

## Verification
Two functions can fall in the same cycle: a snoop lookup with its state update, and a local access to the same set. The bench presents a snoop with write intent and a local write to one Shared line on the same clock edge. It expects the local port to refuse in that cycle, the snoop to report a hit, and the retried write to be accepted one cycle later and report a miss, because the snoop has already invalidated the line. A second overlap is a snoop presented while an implicit writeback is stalled. That snoop must produce no hit, and the line it names must keep its state.

// File: rtl/snpc_pkg.sv
// Shared types for the snoop coherence unit.
package snpc_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_MOD = 2'b10
    } line_st_e;

    typedef enum logic {
        SF_IDLE  = 1'b0,
        SF_WBACK = 1'b1
    } snp_fsm_e;
endpackage

// File: rtl/coh_tag_array.sv
// Direct-mapped tag/state/data store with two combinational lookup ports.
// Assumes: write sources in one cycle apply in the order fill, local write,
// snoop update, so a snoop update to a set wins over the others.
module coh_tag_array
    import snpc_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int TAG_W  = 7,
    parameter int LINE_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [LINE_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [LINE_W-1:0] rb_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              lw_en,
    input  logic [IDX_W-1:0]  lw_idx,
    input  logic [LINE_W-1:0] lw_data,
    input  logic              su_en,
    input  logic [IDX_W-1:0]  su_idx,
    input  line_st_e          su_st
);
    line_st_e          st_v   [SETS];
    logic [TAG_W-1:0]  tag_v  [SETS];
    logic [LINE_W-1:0] data_v [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        line_st_e          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [LINE_W-1:0] data_r;

        // Per-set storage update with fixed write-source ordering.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r   <= LS_INV;
                tag_r  <= '0;
                data_r <= '0;
            end else begin
                if (fill_en && fill_idx == IDX_W'(s)) begin
                    st_r   <= LS_SHR;
                    tag_r  <= fill_tag;
                    data_r <= fill_data;
                end
                if (lw_en && lw_idx == IDX_W'(s)) begin
                    st_r   <= LS_MOD;
                    data_r <= lw_data;
                end
                if (su_en && su_idx == IDX_W'(s)) begin
                    st_r <= su_st;
                end
            end
        end

        assign st_v[s]   = st_r;
        assign tag_v[s]  = tag_r;
        assign data_v[s] = data_r;
    end

    // Lookup port A (snoop side).
    always_comb begin
        ra_st   = st_v[ra_idx];
        ra_tag  = tag_v[ra_idx];
        ra_data = data_v[ra_idx];
    end

    // Lookup port B (local side).
    always_comb begin
        rb_st   = st_v[rb_idx];
        rb_tag  = tag_v[rb_idx];
        rb_data = data_v[rb_idx];
    end

    // R10: the local write and the snoop update never land on one set together.
    a_r10_no_set_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !(su_en && lw_en && su_idx == lw_idx));
endmodule

// File: rtl/coh_snoop_ctl.sv
// Snoop side: accepts a snoop when idle, reports hit and hit-modified one
// cycle later, picks the next line state, and holds an implicit writeback
// of a Modified line until the requester takes it.
// Assumes: the lookup inputs belong to snp_addr's set in the same cycle.
module coh_snoop_ctl
    import snpc_pkg::*;
#(
    parameter int LADDR_W = 10,
    parameter int TAG_W   = 7,
    parameter int LINE_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snp_valid,
    input  logic [LADDR_W-1:0] snp_addr,
    input  logic               snp_wr,
    input  line_st_e           look_st,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [LINE_W-1:0]  look_data,
    input  logic               wb_ready,
    output logic               snp_ready,
    output logic               snp_acc,
    output logic               snp_hit,
    output logic               snp_hitm,
    output logic               wb_valid,
    output logic [LADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0]  wb_data,
    output logic               su_en,
    output line_st_e           su_st
);
    snp_fsm_e fsm_q;
    logic     hit_now, dirty_now;

    assign snp_ready = (fsm_q == SF_IDLE);
    assign snp_acc   = snp_valid && snp_ready;
    assign wb_valid  = (fsm_q == SF_WBACK);

    // Tag compare for the presented snoop.
    always_comb begin
        hit_now   = snp_acc && (look_st != LS_INV)
                    && (look_tag == snp_addr[LADDR_W-1 -: TAG_W]);
        dirty_now = hit_now && (look_st == LS_MOD);
    end

    // Next line state: write intent drops the copy, a read of a dirty line cleans it.
    always_comb begin
        su_en = hit_now && (snp_wr || dirty_now);
        su_st = snp_wr ? LS_INV : LS_SHR;
    end

    // Hit flags, writeback buffer and idle/writeback sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q    <= SF_IDLE;
            snp_hit  <= 1'b0;
            snp_hitm <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else begin
            snp_hit  <= hit_now;
            snp_hitm <= dirty_now;
            if (dirty_now) begin
                fsm_q   <= SF_WBACK;
                wb_addr <= snp_addr;
                wb_data <= look_data;
            end else if (fsm_q == SF_WBACK && wb_ready) begin
                fsm_q <= SF_IDLE;
            end
        end
    end

    // R5: hit-modified never appears without hit.
    a_r5_hitm_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> snp_hit);
    // R6: the writeback is offered together with hit-modified.
    a_r6_wb_with_hitm: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> wb_valid);
    // R6: a stalled writeback keeps its address and data.
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));
    // R7: no snoop is taken while a writeback is pending.
    a_r7_no_accept_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !snp_acc);
endmodule

// File: rtl/coh_local_port.sv
// Local processor port: looks up a read or write, refuses it when a snoop
// is accepted to the same set in that cycle, writes hit data into the
// array, and returns a registered result one cycle later.
// Assumes: the lookup inputs belong to lcl_addr's set in the same cycle.
module coh_local_port
    import snpc_pkg::*;
#(
    parameter int LADDR_W = 10,
    parameter int TAG_W   = 7,
    parameter int IDX_W   = 3,
    parameter int LINE_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lcl_valid,
    input  logic               lcl_wr,
    input  logic [LADDR_W-1:0] lcl_addr,
    input  logic [LINE_W-1:0]  lcl_wdata,
    input  logic               snp_acc,
    input  logic [IDX_W-1:0]   snp_idx,
    input  line_st_e           look_st,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [LINE_W-1:0]  look_data,
    output logic               lcl_ready,
    output logic               lcl_done,
    output logic               lcl_hit,
    output logic [LINE_W-1:0]  lcl_rdata,
    output logic               lw_en,
    output logic [LINE_W-1:0]  lw_data
);
    logic acc, hit_now;

    // Conflict rule: a snoop to the same set goes first.
    always_comb begin
        lcl_ready = !(snp_acc && snp_idx == lcl_addr[IDX_W-1:0]);
        acc       = lcl_valid && lcl_ready;
        hit_now   = acc && (look_st != LS_INV)
                    && (look_tag == lcl_addr[LADDR_W-1 -: TAG_W]);
        lw_en     = hit_now && lcl_wr;
        lw_data   = lcl_wdata;
    end

    // Registered result of the accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcl_done  <= 1'b0;
            lcl_hit   <= 1'b0;
            lcl_rdata <= '0;
        end else begin
            lcl_done  <= acc;
            lcl_hit   <= hit_now;
            lcl_rdata <= (hit_now && !lcl_wr) ? look_data : '0;
        end
    end

    // R11: a result follows only an accepted request.
    a_r11_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_done |-> $past(lcl_valid && lcl_ready));
    // R11: a hit is only reported with a result.
    a_r11_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_hit |-> lcl_done);
endmodule

// File: rtl/snoop_coh_ctrl.sv
// Top of the snoop coherence unit: splits addresses into set and tag,
// connects the snoop controller and local port to the shared array.
// Assumes: line addresses are LADDR_W bits; the low IDX_W bits select the set.
module snoop_coh_ctrl
    import snpc_pkg::*;
#(
    parameter int LADDR_W = 10,
    parameter int SETS    = 8,
    parameter int LINE_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snp_valid,
    input  logic [LADDR_W-1:0] snp_addr,
    input  logic               snp_wr,
    output logic               snp_ready,
    output logic               snp_hit,
    output logic               snp_hitm,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [LADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0]  wb_data,
    input  logic               lcl_valid,
    input  logic               lcl_wr,
    input  logic [LADDR_W-1:0] lcl_addr,
    input  logic [LINE_W-1:0]  lcl_wdata,
    output logic               lcl_ready,
    output logic               lcl_done,
    output logic               lcl_hit,
    output logic [LINE_W-1:0]  lcl_rdata,
    input  logic               fill_valid,
    input  logic [LADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0]  fill_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LADDR_W - IDX_W;

    line_st_e          s_st, l_st, su_st;
    logic [TAG_W-1:0]  s_tag, l_tag;
    logic [LINE_W-1:0] s_data, l_data, lw_data;
    logic              snp_acc, su_en, lw_en;

    coh_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(snp_addr[IDX_W-1:0]), .ra_st(s_st), .ra_tag(s_tag), .ra_data(s_data),
        .rb_idx(lcl_addr[IDX_W-1:0]), .rb_st(l_st), .rb_tag(l_tag), .rb_data(l_data),
        .fill_en(fill_valid), .fill_idx(fill_addr[IDX_W-1:0]),
        .fill_tag(fill_addr[LADDR_W-1 -: TAG_W]), .fill_data(fill_data),
        .lw_en(lw_en), .lw_idx(lcl_addr[IDX_W-1:0]), .lw_data(lw_data),
        .su_en(su_en), .su_idx(snp_addr[IDX_W-1:0]), .su_st(su_st)
    );

    coh_snoop_ctl #(.LADDR_W(LADDR_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_wr(snp_wr),
        .look_st(s_st), .look_tag(s_tag), .look_data(s_data),
        .wb_ready(wb_ready), .snp_ready(snp_ready), .snp_acc(snp_acc),
        .snp_hit(snp_hit), .snp_hitm(snp_hitm),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .su_en(su_en), .su_st(su_st)
    );

    coh_local_port #(.LADDR_W(LADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_local (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
        .snp_acc(snp_acc), .snp_idx(snp_addr[IDX_W-1:0]),
        .look_st(l_st), .look_tag(l_tag), .look_data(l_data),
        .lcl_ready(lcl_ready), .lcl_done(lcl_done), .lcl_hit(lcl_hit), .lcl_rdata(lcl_rdata),
        .lw_en(lw_en), .lw_data(lw_data)
    );
endmodule

// File: tb/sim_snoop_coh_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_snoop_coh_ctrl;
    localparam int LADDR_W = 10;
    localparam int LINE_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 1'b0, snp_wr = 1'b0, wb_ready = 1'b0;
    logic [LADDR_W-1:0] snp_addr = '0, lcl_addr = '0, fill_addr = '0;
    logic lcl_valid = 1'b0, lcl_wr = 1'b0, fill_valid = 1'b0;
    logic [LINE_W-1:0] lcl_wdata = '0, fill_data = '0;
    logic snp_ready, snp_hit, snp_hitm, wb_valid, lcl_ready, lcl_done, lcl_hit;
    logic [LADDR_W-1:0] wb_addr;
    logic [LINE_W-1:0] wb_data, lcl_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    snoop_coh_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_wr(snp_wr),
        .snp_ready(snp_ready), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .lcl_valid(lcl_valid), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
        .lcl_ready(lcl_ready), .lcl_done(lcl_done), .lcl_hit(lcl_hit), .lcl_rdata(lcl_rdata),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    // Sets: 0x012 -> set 2, 0x01A -> set 2 other tag, 0x024 -> set 4,
    // 0x036 -> set 6, 0x015 -> set 5.
    localparam logic [LADDR_W-1:0] AD_A = 10'h012;
    localparam logic [LADDR_W-1:0] AD_X = 10'h01A;
    localparam logic [LADDR_W-1:0] AD_B = 10'h024;
    localparam logic [LADDR_W-1:0] AD_C = 10'h036;
    localparam logic [LADDR_W-1:0] AD_E = 10'h015;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [LADDR_W-1:0] a, input logic [LINE_W-1:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // One snoop; on return the registered hit flags are visible.
    task automatic snoop(input logic [LADDR_W-1:0] a, input bit wr,
                         input bit e_hit, input bit e_hitm, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a; snp_wr = wr;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_hit == e_hit, req, 64'(snp_hit), 64'(e_hit));
        chk(snp_hitm == e_hitm, req, 64'(snp_hitm), 64'(e_hitm));
    endtask

    task automatic local_acc(input logic [LADDR_W-1:0] a, input bit wr, input logic [LINE_W-1:0] d,
                             input bit e_hit, input logic [LINE_W-1:0] e_rd, input string req);
        @(negedge clk);
        lcl_valid = 1'b1; lcl_addr = a; lcl_wr = wr; lcl_wdata = d;
        @(negedge clk);
        lcl_valid = 1'b0;
        chk(lcl_done == 1'b1, req, 64'(lcl_done), 64'd1);
        chk(lcl_hit == e_hit, req, 64'(lcl_hit), 64'(e_hit));
        if (!wr) chk(lcl_rdata == e_rd, req, 64'(lcl_rdata), 64'(e_rd));
    endtask

    task automatic wb_take(input string req);
        @(negedge clk);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
        chk(wb_valid == 1'b0, req, 64'(wb_valid), 64'd0);
        chk(snp_ready == 1'b1, req, 64'(snp_ready), 64'd1);
    endtask

    task automatic t_reset();
        chk(snp_ready == 1'b1, "R1", 64'(snp_ready), 64'd1);
        chk(snp_hit == 1'b0 && snp_hitm == 1'b0, "R1", 64'({snp_hit, snp_hitm}), 64'd0);
        chk(wb_valid == 1'b0, "R1", 64'(wb_valid), 64'd0);
        chk(lcl_done == 1'b0, "R1", 64'(lcl_done), 64'd0);
        local_acc(AD_A, 1'b0, '0, 1'b0, '0, "R1");
    endtask

    task automatic t_fill_read();
        fill(AD_A, 32'h1111_0001);
        local_acc(AD_A, 1'b0, '0, 1'b1, 32'h1111_0001, "R9");
        local_acc(AD_X, 1'b0, '0, 1'b0, '0, "R11");
    endtask

    task automatic t_snoop_read_shared();
        snoop(AD_A, 1'b0, 1'b1, 1'b0, "R2");
        chk(wb_valid == 1'b0, "R2", 64'(wb_valid), 64'd0);
        snoop(AD_A, 1'b0, 1'b1, 1'b0, "R2");
        local_acc(AD_A, 1'b0, '0, 1'b1, 32'h1111_0001, "R2");
    endtask

    task automatic t_snoop_miss();
        snoop(AD_X, 1'b1, 1'b0, 1'b0, "R4");
        snoop(AD_E, 1'b0, 1'b0, 1'b0, "R4");
        local_acc(AD_A, 1'b0, '0, 1'b1, 32'h1111_0001, "R4");
    endtask

    task automatic t_snoop_write_shared();
        snoop(AD_A, 1'b1, 1'b1, 1'b0, "R3");
        local_acc(AD_A, 1'b0, '0, 1'b0, '0, "R3");
        fill(AD_A, 32'h1111_0002);
        local_acc(AD_A, 1'b0, '0, 1'b1, 32'h1111_0002, "R3");
    endtask

    task automatic t_local_write_miss();
        local_acc(AD_B, 1'b1, 32'hDEAD_0000, 1'b0, '0, "R9");
        local_acc(AD_B, 1'b0, '0, 1'b0, '0, "R9");
    endtask

    task automatic t_wb_read();
        fill(AD_B, 32'h2222_0000);
        local_acc(AD_B, 1'b1, 32'h2222_ABCD, 1'b1, '0, "R9");
        snoop(AD_B, 1'b0, 1'b1, 1'b1, "R5");
        chk(wb_valid == 1'b1, "R6", 64'(wb_valid), 64'd1);
        chk(wb_data == 32'h2222_ABCD, "R6", 64'(wb_data), 64'h2222_ABCD);
        chk(wb_addr == AD_B, "R6", 64'(wb_addr), 64'(AD_B));
        chk(snp_ready == 1'b0, "R7", 64'(snp_ready), 64'd0);
        // A snoop with write intent to Shared line A is presented during the stall.
        snp_valid = 1'b1; snp_addr = AD_A; snp_wr = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(snp_hit == 1'b0, "R7", 64'(snp_hit), 64'd0);
            chk(snp_hitm == 1'b0, "R5", 64'(snp_hitm), 64'd0);
            chk(wb_valid == 1'b1 && wb_data == 32'h2222_ABCD && wb_addr == AD_B, "R6",
                64'(wb_data), 64'h2222_ABCD);
        end
        snp_valid = 1'b0;
        wb_take("R7");
        local_acc(AD_A, 1'b0, '0, 1'b1, 32'h1111_0002, "R7");
        snoop(AD_B, 1'b0, 1'b1, 1'b0, "R8");
    endtask

    task automatic t_wb_write();
        local_acc(AD_B, 1'b1, 32'h3333_5555, 1'b1, '0, "R9");
        @(negedge clk);
        wb_ready = 1'b1;
        snoop(AD_B, 1'b1, 1'b1, 1'b1, "R5");
        chk(wb_valid == 1'b1 && wb_data == 32'h3333_5555, "R6", 64'(wb_data), 64'h3333_5555);
        @(negedge clk);
        wb_ready = 1'b0;
        chk(wb_valid == 1'b0 && snp_ready == 1'b1, "R7", 64'(wb_valid), 64'd0);
        snoop(AD_B, 1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_conflict();
        fill(AD_C, 32'h4444_0000);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = AD_C; snp_wr = 1'b1;
        lcl_valid = 1'b1; lcl_addr = AD_C; lcl_wr = 1'b1; lcl_wdata = 32'h4444_FFFF;
        #1;
        chk(lcl_ready == 1'b0, "R10", 64'(lcl_ready), 64'd0);
        chk(snp_ready == 1'b1, "R10", 64'(snp_ready), 64'd1);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_hit == 1'b1 && snp_hitm == 1'b0, "R10", 64'({snp_hit, snp_hitm}), 64'd2);
        chk(lcl_done == 1'b0, "R10", 64'(lcl_done), 64'd0);
        #1;
        chk(lcl_ready == 1'b1, "R10", 64'(lcl_ready), 64'd1);
        @(negedge clk);
        lcl_valid = 1'b0;
        chk(lcl_done == 1'b1 && lcl_hit == 1'b0, "R10", 64'({lcl_done, lcl_hit}), 64'd2);
        snoop(AD_C, 1'b0, 1'b0, 1'b0, "R10");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_read();
        t_snoop_read_shared();
        t_snoop_miss();
        t_snoop_write_shared();
        t_local_write_miss();
        t_wb_read();
        t_wb_write();
        t_conflict();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule